// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit sits between the memory stage of a 32-bit load/store pipeline and a byte-addressable, word-wide data memory port. It forms the effective address from a base register and a signed 16-bit displacement. It checks that the address fits the access size, and it turns the request into a memory request with per-lane byte-enables and write data. An access that does not fit its size is aborted: it raises a fault and reaches no memory.

On the load side, the unit picks the addressed byte or halfword out of the returned word. It then sign-extends or zero-extends the item and registers the result. An upper-immediate operation yields its result through the same registered output without touching memory. The `big_endian_i` input selects the byte order. Under little-endian order, address offset 0 maps to the least significant lane. Under big-endian order, it maps to the most significant lane.

Control is a two-state machine. In `ST_IDLE` a request is accepted. A load that issues takes the transition `issue_load` into `ST_WAIT`. Stores, upper-immediate operations, faulted accesses and no-ops take `stay_idle` and remain in `ST_IDLE`. In `ST_WAIT` the unit waits for the memory response. It takes `rsp_return` back to `ST_IDLE` when the response arrives, and `hold_wait` while none has arrived.

Top module: `lsu_align_unit`

## Requirements
- R1: `mem_addr_o` equals `base_i` plus `disp_i` sign-extended to 32 bits, in the same cycle as the request.
- R2: Size codes are 0 = byte, 1 = halfword, 2 = word and 3 = reserved. For a load or store accepted in `ST_IDLE`, `fault_o` rises in the same cycle under either of two conditions. The first is that the size is halfword and address bit 0 is 1. The second is that the size is word and address bits 1:0 are not 00. The reserved size always faults.
- R3: A faulted access drives `mem_be_o` to 0 and holds `mem_req_o` and `mem_we_o` low. It leaves the state in `ST_IDLE` and produces no load result.
- R4: Let `a` be address bits 1:0. With little-endian order (`big_endian_i`=0), a byte access enables lane `a` and a halfword access enables lanes `a` and `a+1`. With big-endian order, a byte access enables lane `3-a` and a halfword access enables lanes `2-a` and `3-a`. A word access enables all four lanes. Lane k is bits 8k+7:8k of the data word.
- R5: Store write data repeats the low byte of `st_data_i` in all four lanes for a byte store. It repeats the low halfword in both halves for a halfword store, and it passes the full word for a word store. `mem_we_o` is high only for an accepted, non-faulting store.
- R6: A load takes its item from the lanes that R4 enables: lane `L` for a byte, and lanes `L+1:L` as one 16-bit value for a halfword.
- R7: Operation codes are 0 = load, 1 = store, 2 = upper-immediate and 3 = no-op. A byte or halfword load sign-extends the item when `req_unsigned_i` is 0 and zero-extends it when `req_unsigned_i` is 1.
- R8: An upper-immediate request loads `{disp_i, 16'h0000}` into `ld_data_o`, and `ld_valid_o` is high in the next cycle.
- R9: `ld_valid_o` rises in the cycle after `rsp_valid_i` is sampled high in `ST_WAIT`. It stays high for one cycle, and `ld_data_o` holds its value afterwards.
- R10: In `ST_WAIT`, `req_ready_o` is low and a presented request causes no memory request. In `ST_IDLE`, `rsp_valid_i` causes no load result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian_i | input | 1 | Byte order: 1 = big-endian |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | 0 load, 1 store, 2 upper-immediate, 3 no-op |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_unsigned_i | input | 1 | Zero-extend a sub-word load |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement, or the immediate for an upper-immediate request |
| st_data_i | input | 32 | Store register data |
| req_ready_o | output | 1 | The unit is in `ST_IDLE` |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Effective address |
| mem_be_o | output | 4 | Lane byte-enables |
| mem_wdata_o | output | 32 | Lane-formatted write data |
| fault_o | output | 1 | Misaligned or reserved-size access aborted |
| rsp_valid_i | input | 1 | Memory read data valid |
| rsp_data_i | input | 32 | Memory read word |
| ld_valid_o | output | 1 | Load or upper-immediate result valid |
| ld_data_o | output | 32 | Extended load result |

## Verification
The assertions assume that memory returns exactly one response for each issued load, and that this response arrives only while the unit is in `ST_WAIT`. They also assume that `big_endian_i` stays stable from load issue until the response. The bench follows these rules in every scenario. It raises `rsp_valid_i` once per issued load, after zero or more idle cycles, and it changes the byte order only between accesses. A stray response in `ST_IDLE` is presented on purpose, but only to show that it is ignored.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
    typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_LUI = 2'd2, OP_NONE = 2'd3} lsu_op_e;
    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} lsu_size_e;
    typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} lsu_state_e;
    typedef struct packed {
        logic [1:0] lane;
        lsu_size_e  size;
        logic       unsgn;
    } ld_ctx_t;
endpackage

// File: rtl/lsu_addr_check.sv
module lsu_addr_check
    import lsu_align_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] disp,
    input  lsu_size_e     size,
    input  logic          big_endian,
    output logic [AW-1:0] eff_addr,
    output logic [1:0]    lane,
    output logic          misalign
);
    localparam int EXT_W = AW - DW;

    logic [1:0] off;

    assign eff_addr = base + {{EXT_W{disp[DW-1]}}, disp};
    assign off      = eff_addr[1:0];

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                lane     = big_endian ? ~off : off;
                misalign = 1'b0;
            end
            SZ_HALF: begin
                lane     = big_endian ? {~off[1], 1'b0} : {off[1], 1'b0};
                misalign = off[0];
            end
            SZ_WORD: begin
                lane     = 2'd0;
                misalign = |off;
            end
            default: begin
                lane     = 2'd0;
                misalign = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt
    import lsu_align_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic            en,
    input  lsu_size_e       size,
    input  logic [1:0]      lane,
    input  logic [8*NB-1:0] data,
    output logic [NB-1:0]   be,
    output logic [8*NB-1:0] wdata
);
    for (genvar g = 0; g < NB; g++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: wdata[8*g +: 8] = data[7:0];
                SZ_HALF: wdata[8*g +: 8] = data[8*(g%2) +: 8];
                default: wdata[8*g +: 8] = data[8*g +: 8];
            endcase
        end
    end

    always_comb begin
        be = '0;
        if (en) begin
            unique case (size)
                SZ_BYTE: be = NB'(1) << lane;
                SZ_HALF: be = NB'(3) << lane;
                default: be = '1;
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
    import lsu_align_pkg::*;
#(
    parameter int XW = 32
) (
    input  logic [XW-1:0] word,
    input  ld_ctx_t       ctx,
    output logic [XW-1:0] result
);
    logic [XW-1:0] shifted;
    logic [7:0]    b;
    logic [15:0]   h;

    assign shifted = word >> (8 * ctx.lane);
    assign b       = shifted[7:0];
    assign h       = shifted[15:0];

    always_comb begin
        unique case (ctx.size)
            SZ_BYTE: result = {{(XW-8){b[7] & ~ctx.unsgn}}, b};
            SZ_HALF: result = {{(XW-16){h[15] & ~ctx.unsgn}}, h};
            default: result = word;
        endcase
    end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_align_pkg::*;
#(
    parameter int XW = 32,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          big_endian_i,
    input  logic          req_valid_i,
    input  logic [1:0]    req_op_i,
    input  logic [1:0]    req_size_i,
    input  logic          req_unsigned_i,
    input  logic [XW-1:0] base_i,
    input  logic [DW-1:0] disp_i,
    input  logic [XW-1:0] st_data_i,
    output logic          req_ready_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [XW-1:0] mem_addr_o,
    output logic [XW/8-1:0] mem_be_o,
    output logic [XW-1:0] mem_wdata_o,
    output logic          fault_o,
    input  logic          rsp_valid_i,
    input  logic [XW-1:0] rsp_data_i,
    output logic          ld_valid_o,
    output logic [XW-1:0] ld_data_o
);
    localparam int NB = XW / 8;

    lsu_state_e state_q, state_d;
    lsu_op_e    op;
    lsu_size_e  size;
    logic       accept, mem_access, misalign, issue_ld, rsp_take, lui_take;
    logic [1:0] lane;
    ld_ctx_t    ctx_q;
    logic [XW-1:0] ext_word;
    logic          ld_valid_q;
    logic [XW-1:0] ld_data_q;

    assign op   = lsu_op_e'(req_op_i);
    assign size = lsu_size_e'(req_size_i);

    lsu_addr_check #(.AW(XW), .DW(DW)) addr_i (
        .base(base_i), .disp(disp_i), .size(size), .big_endian(big_endian_i),
        .eff_addr(mem_addr_o), .lane(lane), .misalign(misalign)
    );

    lsu_store_fmt #(.NB(NB)) fmt_i (
        .en(mem_req_o), .size(size), .lane(lane), .data(st_data_i),
        .be(mem_be_o), .wdata(mem_wdata_o)
    );

    lsu_load_ext #(.XW(XW)) ext_i (
        .word(rsp_data_i), .ctx(ctx_q), .result(ext_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d     = state_q;
        req_ready_o = 1'b0;
        accept      = 1'b0;
        rsp_take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready_o = 1'b1;
                accept      = req_valid_i;
                if (issue_ld) state_d = ST_WAIT;       // issue_load
            end
            ST_WAIT: begin
                rsp_take = rsp_valid_i;
                if (rsp_valid_i) state_d = ST_IDLE;    // rsp_return
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign mem_access = accept && (op == OP_LOAD || op == OP_STORE);
    assign fault_o    = mem_access && misalign;
    assign mem_req_o  = mem_access && !misalign;
    assign mem_we_o   = mem_req_o && (op == OP_STORE);
    assign issue_ld   = mem_req_o && (op == OP_LOAD);
    assign lui_take   = accept && (op == OP_LUI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q      <= '0;
            ld_valid_q <= 1'b0;
            ld_data_q  <= '0;
        end else begin
            if (issue_ld) ctx_q <= '{lane: lane, size: size, unsgn: req_unsigned_i};
            ld_valid_q <= rsp_take || lui_take;
            if (rsp_take)      ld_data_q <= ext_word;
            else if (lui_take) ld_data_q <= {disp_i, {(XW-DW){1'b0}}};
        end
    end

    assign ld_valid_o = ld_valid_q;
    assign ld_data_o  = ld_data_q;

    // R3
    fault_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (mem_be_o == '0 && !mem_req_o && !mem_we_o));

    // R4
    byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && size == SZ_BYTE) |-> $countones(mem_be_o) == 1);

    // R2
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && size == SZ_WORD) |-> mem_addr_o[1:0] == 2'b00);

    // R9
    rsp_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready_o && rsp_valid_i) |=> ld_valid_o);

    // R10
    wait_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready_o |-> !mem_req_o);

    // R8
    lui_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready_o && req_valid_i && req_op_i == 2'd2) |=> ld_valid_o);
endmodule

// File: tb/lsu_align_unit_tb_top.sv
module lsu_align_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic big_endian_i = 1'b0;
    logic req_valid_i = 1'b0;
    logic [1:0] req_op_i = 2'd3;
    logic [1:0] req_size_i = 2'd0;
    logic req_unsigned_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] disp_i = '0;
    logic [31:0] st_data_i = '0;
    logic rsp_valid_i = 1'b0;
    logic [31:0] rsp_data_i = '0;
    logic req_ready_o, mem_req_o, mem_we_o, fault_o, ld_valid_o;
    logic [31:0] mem_addr_o, mem_wdata_o, ld_data_o;
    logic [3:0] mem_be_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lsu_align_unit dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [1:0] sz, input logic uns,
                         input logic be, input logic [31:0] base, input logic [15:0] disp,
                         input logic [31:0] sd);
        @(negedge clk);
        req_valid_i = 1'b1; req_op_i = op; req_size_i = sz; req_unsigned_i = uns;
        big_endian_i = be; base_i = base; disp_i = disp; st_data_i = sd;
        #1;
    endtask

    task automatic idle_req();
        @(posedge clk);
        @(negedge clk);
        req_valid_i = 1'b0; req_op_i = 2'd3;
    endtask

    task automatic t_reset();
        chk("R10 reset ready", {31'd0, req_ready_o}, 32'd1);
        chk("R9 reset ld_valid", {31'd0, ld_valid_o}, 32'd0);
        chk("R3 reset mem_req", {31'd0, mem_req_o}, 32'd0);
    endtask

    task automatic t_store(input logic [1:0] sz, input logic be, input logic [31:0] addr,
                           input logic [31:0] sd, input logic [3:0] exp_be,
                           input logic [31:0] exp_wd);
        drive(2'd1, sz, 1'b0, be, addr, 16'h0000, sd);
        chk("R4 store be", {28'd0, mem_be_o}, {28'd0, exp_be});
        chk("R5 store wdata", mem_wdata_o, exp_wd);
        chk("R5 store we", {31'd0, mem_we_o}, 32'd1);
        idle_req();
    endtask

    task automatic t_addr();
        drive(2'd1, 2'd2, 1'b0, 1'b0, 32'h0000_1000, 16'hFFFC, 32'h0);
        chk("R1 eff addr neg", mem_addr_o, 32'h0000_0FFC);
        idle_req();
        drive(2'd3, 2'd0, 1'b0, 1'b0, 32'h0000_2000, 16'h0104, 32'h0);
        chk("R1 eff addr pos", mem_addr_o, 32'h0000_2104);
        idle_req();
    endtask

    task automatic t_fault(input logic [1:0] op, input logic [1:0] sz, input logic [31:0] addr);
        drive(op, sz, 1'b0, 1'b0, addr, 16'h0000, 32'hFFFF_FFFF);
        chk("R2 fault", {31'd0, fault_o}, 32'd1);
        chk("R3 fault be", {28'd0, mem_be_o}, 32'd0);
        chk("R3 fault req", {30'd0, mem_req_o, mem_we_o}, 32'd0);
        idle_req();
        #1;
        chk("R3 fault stays idle", {31'd0, req_ready_o}, 32'd1);
        chk("R3 fault no result", {31'd0, ld_valid_o}, 32'd0);
    endtask

    task automatic t_load(input logic [1:0] sz, input logic uns, input logic be,
                          input logic [31:0] addr, input logic [31:0] word,
                          input int gap, input logic [3:0] exp_be, input logic [31:0] exp);
        drive(2'd0, sz, uns, be, addr, 16'h0000, 32'h0);
        chk("R4 load be", {28'd0, mem_be_o}, {28'd0, exp_be});
        chk("R5 load no we", {31'd0, mem_we_o}, 32'd0);
        idle_req();
        for (int i = 0; i < gap; i++) begin
            // present another request while waiting
            req_valid_i = 1'b1; req_op_i = 2'd1; req_size_i = 2'd2; base_i = 32'h0;
            #1;
            chk("R10 wait ready low", {31'd0, req_ready_o}, 32'd0);
            chk("R10 wait no req", {31'd0, mem_req_o}, 32'd0);
            chk("R9 no early valid", {31'd0, ld_valid_o}, 32'd0);
            idle_req();
        end
        rsp_valid_i = 1'b1; rsp_data_i = word;
        @(posedge clk);
        @(negedge clk);
        rsp_valid_i = 1'b0; rsp_data_i = 32'hDEAD_BEEF;
        #1;
        chk("R9 valid after rsp", {31'd0, ld_valid_o}, 32'd1);
        chk("R6 R7 load data", ld_data_o, exp);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R9 single pulse", {31'd0, ld_valid_o}, 32'd0);
        chk("R9 data held", ld_data_o, exp);
    endtask

    task automatic t_lui();
        drive(2'd2, 2'd0, 1'b0, 1'b0, 32'h1234_5678, 16'hABCD, 32'h0);
        chk("R8 lui no mem", {31'd0, mem_req_o}, 32'd0);
        idle_req();
        #1;
        chk("R8 lui valid", {31'd0, ld_valid_o}, 32'd1);
        chk("R8 lui data", ld_data_o, 32'hABCD_0000);
    endtask

    task automatic t_stray_rsp();
        @(negedge clk);
        rsp_valid_i = 1'b1; rsp_data_i = 32'h1111_1111;
        @(posedge clk);
        @(negedge clk);
        rsp_valid_i = 1'b0;
        #1;
        chk("R10 idle rsp ignored", {31'd0, ld_valid_o}, 32'd0);
        chk("R10 idle rsp data kept", ld_data_o, 32'hABCD_0000);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_addr();
        t_store(2'd0, 1'b0, 32'h101, 32'h0000_005A, 4'b0010, 32'h5A5A_5A5A);
        t_store(2'd0, 1'b1, 32'h101, 32'h0000_005A, 4'b0100, 32'h5A5A_5A5A);
        t_store(2'd1, 1'b0, 32'h102, 32'h1234_BEEF, 4'b1100, 32'hBEEF_BEEF);
        t_store(2'd1, 1'b1, 32'h102, 32'h1234_BEEF, 4'b0011, 32'hBEEF_BEEF);
        t_store(2'd1, 1'b1, 32'h100, 32'h1234_BEEF, 4'b1100, 32'hBEEF_BEEF);
        t_store(2'd2, 1'b1, 32'h100, 32'hCAFE_F00D, 4'b1111, 32'hCAFE_F00D);
        t_fault(2'd1, 2'd1, 32'h201);
        t_fault(2'd0, 2'd2, 32'h202);
        t_fault(2'd0, 2'd3, 32'h200);
        t_load(2'd0, 1'b0, 1'b0, 32'h303, 32'h8000_0000, 0, 4'b1000, 32'hFFFF_FF80);
        t_load(2'd0, 1'b1, 1'b0, 32'h303, 32'h8000_0000, 1, 4'b1000, 32'h0000_0080);
        t_load(2'd0, 1'b0, 1'b1, 32'h300, 32'h8000_0000, 0, 4'b1000, 32'hFFFF_FF80);
        t_load(2'd0, 1'b0, 1'b1, 32'h303, 32'h0000_0071, 0, 4'b0001, 32'h0000_0071);
        t_load(2'd1, 1'b0, 1'b1, 32'h300, 32'h8001_0000, 2, 4'b1100, 32'hFFFF_8001);
        t_load(2'd1, 1'b1, 1'b0, 32'h300, 32'h1234_8001, 0, 4'b0011, 32'h0000_8001);
        t_load(2'd1, 1'b0, 1'b0, 32'h302, 32'h7FFE_0000, 0, 4'b1100, 32'h0000_7FFE);
        t_load(2'd2, 1'b0, 1'b1, 32'h304, 32'h89AB_CDEF, 0, 4'b1111, 32'h89AB_CDEF);
        t_lui();
        t_stray_rsp();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule